// File: doc/BRIEF.md
# Access-Sequenced Integer Math Unit

This block is a multi-cycle integer arithmetic unit that sits on a byte-wide register bus. Software sees four addresses: an A operand/result register, a B operand/result register, a control/count register and a status register. There is no opcode field. The unit works out which operation is wanted from the order and number of byte writes to A, B and the control register. The last write of a valid pattern starts the operation. After a fixed number of cycles the result can be read back byte by byte.

Five operations are supported:
- a 32-by-16 divide
- a 16-by-16 divide
- a 16-by-16 multiply
- a 32-bit logical shift in either direction
- a 32-bit normalize

Each is computed one bit per cycle by an iterative engine. A timer holds the busy indication for the latency fixed for that operation.

A sequencer state machine tracks the load pattern with these states:
- `ST_IDLE` (no load in progress)
- `ST_A1`, `ST_A2`, `ST_A3`, `ST_A4` (one to four A writes)
- `ST_A2B` (two A writes, one B write)
- `ST_A4B` (four A writes, one B write)
- `ST_B1` (one B write)
- `ST_B1A1`, `ST_B1A2` (one B write, then one or two A writes)
- `ST_RUN` (executing)
- `ST_FAULT` (sequence broken)

The transitions are:
- From `ST_IDLE`: an A write goes to `ST_A1`, a B write goes to `ST_B1`, and a control write goes to `ST_FAULT`.
- A writes step through `ST_A1` to `ST_A4`.
- A B write in `ST_A2` goes to `ST_A2B`, and a B write in `ST_A4` goes to `ST_A4B`.
- A writes step `ST_B1` to `ST_B1A1` and then to `ST_B1A2`.
- These writes start an operation and go to `ST_RUN`:
  - a B write in `ST_A2B`, `ST_A4B` or `ST_B1A2`
  - a control write in `ST_A4`
- `ST_RUN` returns to `ST_IDLE` on the final execution cycle.
- Any other A, B or control access, or an A/B read, in a loading state or in `ST_RUN` goes to `ST_FAULT`. A/B reads in `ST_IDLE` are allowed.
- `ST_FAULT` is left only by the clear write described below, which returns any state to `ST_IDLE`.

Top module: `seqmath_unit`

## Requirements
- R1: After reset the status register (address 3) reads 0x00 and an A-register read (address 0) returns 0x00.
- R2: Four writes to A (address 0) followed by two writes to B (address 1) start a 32/16 divide. A then yields the 32-bit quotient and B the 16-bit remainder. The busy phase lasts 36 cycles.
- R3: Two writes to A followed by two writes to B start a 16/16 divide. A then yields the 16-bit quotient, zero-extended to 32 bits, and B the remainder. The busy phase lasts 24 cycles.
- R4: A B write, two A writes and a second B write start a 16x16 multiply. The multiplicand is the A bytes and the multiplier is the two B bytes. A yields the 32-bit product, after 24 cycles.
- R5: Four A writes followed by a write to the control register (address 2) with bit 6 clear start a logical shift of the 32-bit A value. Bit 5 set selects right and clear selects left, and bits 4:0 give the distance. The busy phase lasts 36 cycles.
- R6: The same pattern with control bit 6 set normalizes the value. It shifts left until bit 31 is set, at most 31 places. A gives the mantissa and B the shift count (0..31), so a zero input gives mantissa 0 and count 31. The busy phase lasts 36 cycles.
- R7: Operand bytes are written most significant first. Results are read least significant first: A reads cycle through 4 bytes and then wrap to the first, and B reads cycle through 2 bytes. The read positions restart when an operation ends.
- R8: A divide with a zero divisor sets status bit 1 and leaves A reading all ones (4 bytes) and B all ones (2 bytes).
- R9: Reads and writes to addresses 4 to 7 between accelerator accesses do not affect the load sequence or the result.
- R10: An out-of-order access sets status bit 2 (fault) and aborts any running operation. While faulted, A/B/control accesses start nothing.
- R11: Writing the status register with bit 2 clear clears the fault and error bits and returns the sequencer to idle. A status write with bit 2 set changes nothing.
- R12: Status bit 0 (busy) rises on the cycle after the starting write and stays high for exactly the latency of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | ADDR_W (3) | Register select: 0 A, 1 B, 2 control, 3 status, others unrelated |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address during a read, 0 otherwise |

## Verification
Let E0 be the clock edge that takes the final write of a pattern. Busy shows from E0, and results are due at edge E0+24 for the multiply and the short divide, and at E0+36 for the long divide, shift and normalize. The bench reads status in every cycle after the final write and counts edges until busy drops, comparing the count with the latency. Result reads begin only one edge after that. Scoreboard entries are pushed when each read is issued and compared at the falling edge of that same cycle. A fault caused during execution is expected to clear busy one edge after the offending access, and the bench waits that extra cycle before it checks.

// File: rtl/seqmath_pkg.sv
package seqmath_pkg;
    localparam int LAT_LONG  = 36;
    localparam int LAT_SHORT = 24;
    localparam int CTL_RIGHT = 5;
    localparam int CTL_NORM  = 6;

    typedef enum logic [2:0] {
        OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT, OP_NORM
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_A1, ST_A2, ST_A3, ST_A4, ST_A2B, ST_A4B,
        ST_B1, ST_B1A1, ST_B1A2, ST_RUN, ST_FAULT
    } seq_e;
endpackage

// File: rtl/seqmath_seq.sv
module seqmath_seq
    import seqmath_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_a,
    input  logic wr_b,
    input  logic wr_c,
    input  logic rd_a,
    input  logic rd_b,
    input  logic clr,
    input  logic done,
    input  logic ctl_norm,
    output logic start,
    output op_e  op,
    output seq_e state
);
    seq_e nxt;
    logic any_acc;

    assign any_acc = wr_a | wr_b | wr_c | rd_a | rd_b;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wr_a) nxt = ST_A1; else if (wr_b) nxt = ST_B1;
                      else if (wr_c) nxt = ST_FAULT;
            ST_A1:    if (wr_a) nxt = ST_A2; else if (any_acc) nxt = ST_FAULT;
            ST_A2:    if (wr_a) nxt = ST_A3; else if (wr_b) nxt = ST_A2B;
                      else if (any_acc) nxt = ST_FAULT;
            ST_A3:    if (wr_a) nxt = ST_A4; else if (any_acc) nxt = ST_FAULT;
            ST_A4:    if (wr_b) nxt = ST_A4B; else if (wr_c) nxt = ST_RUN;
                      else if (any_acc) nxt = ST_FAULT;
            ST_A2B,
            ST_A4B,
            ST_B1A2:  if (wr_b) nxt = ST_RUN; else if (any_acc) nxt = ST_FAULT;
            ST_B1:    if (wr_a) nxt = ST_B1A1; else if (any_acc) nxt = ST_FAULT;
            ST_B1A1:  if (wr_a) nxt = ST_B1A2; else if (any_acc) nxt = ST_FAULT;
            ST_RUN:   if (any_acc) nxt = ST_FAULT; else if (done) nxt = ST_IDLE;
            ST_FAULT: nxt = ST_FAULT;
            default:  nxt = ST_IDLE;
        endcase
        if (clr) nxt = ST_IDLE;
    end

    always_comb begin
        start = 1'b0;
        op    = OP_DIV32;
        unique case (state)
            ST_A4:   begin start = wr_c; op = ctl_norm ? OP_NORM : OP_SHIFT; end
            ST_A2B:  begin start = wr_b; op = OP_DIV16; end
            ST_A4B:  begin start = wr_b; op = OP_DIV32; end
            ST_B1A2: begin start = wr_b; op = OP_MUL;   end
            default: begin start = 1'b0; op = OP_DIV32; end
        endcase
        if (clr) start = 1'b0;
    end

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !clr) |=> state == ST_FAULT); // R10
    AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state == ST_IDLE); // R11
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> state == ST_RUN); // R12
endmodule

// File: rtl/seqmath_engine.sv
module seqmath_engine
    import seqmath_pkg::*;
#(
    parameter int LAT_L = LAT_LONG,
    parameter int LAT_S = LAT_SHORT
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        abort,
    input  op_e         op_in,
    input  logic [31:0] opa,
    input  logic [15:0] opb,
    input  logic [5:0]  ctl,
    output logic        busy,
    output logic        done,
    output logic        dz,
    output logic [31:0] res_a,
    output logic [15:0] res_b
);
    localparam int TW = $clog2(LAT_L + 1);

    op_e           op_q;
    logic [TW-1:0] timer;
    logic [5:0]    steps;
    logic [31:0]   q;
    logic [15:0]   aux, dv, mp;
    logic          right_q;
    logic [16:0]   trial, diffv;
    logic          ge;
    logic [15:0]   nrem;

    assign trial = {aux, q[31]};
    assign diffv = trial - {1'b0, dv};
    assign ge    = trial >= {1'b0, dv};
    assign nrem  = ge ? diffv[15:0] : trial[15:0];
    assign done  = busy && (timer == '0) && !abort;
    assign res_a = q;
    assign res_b = aux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; dz <= 1'b0; op_q <= OP_DIV32; timer <= '0;
            steps <= '0; q <= '0; aux <= '0; dv <= '0; mp <= '0; right_q <= 1'b0;
        end else if (abort) begin
            busy <= 1'b0;
            dz   <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            dz      <= 1'b0;
            op_q    <= op_in;
            right_q <= ctl[CTL_RIGHT];
            timer   <= (op_in == OP_MUL || op_in == OP_DIV16) ? TW'(LAT_S - 1) : TW'(LAT_L - 1);
            aux     <= '0;
            unique case (op_in)
                OP_DIV32, OP_DIV16: begin
                    if (opb == 16'h0) begin
                        dz <= 1'b1; q <= '1; aux <= '1; steps <= '0;
                    end else begin
                        q     <= (op_in == OP_DIV32) ? opa : {opa[15:0], 16'h0};
                        dv    <= opb;
                        steps <= (op_in == OP_DIV32) ? 6'd32 : 6'd16;
                    end
                end
                OP_MUL:   begin q <= '0; dv <= opa[15:0]; mp <= opb; steps <= 6'd16; end
                OP_SHIFT: begin q <= opa; steps <= {1'b0, ctl[4:0]}; end
                OP_NORM:  begin q <= opa; steps <= 6'd31; end
                default:  steps <= '0;
            endcase
        end else if (busy) begin
            if (timer == '0) busy <= 1'b0;
            else             timer <= timer - 1'b1;
            if (steps != '0) begin
                steps <= steps - 1'b1;
                case (op_q)
                    OP_DIV32, OP_DIV16: begin q <= {q[30:0], ge}; aux <= nrem; end
                    OP_MUL: begin
                        q  <= {q[30:0], 1'b0} + (mp[15] ? {16'h0, dv} : 32'h0);
                        mp <= {mp[14:0], 1'b0};
                    end
                    OP_SHIFT: q <= right_q ? {1'b0, q[31:1]} : {q[30:0], 1'b0};
                    OP_NORM: begin
                        if (q[31]) steps <= '0;
                        else begin q <= {q[30:0], 1'b0}; aux <= aux + 1'b1; end
                    end
                    default: steps <= '0;
                endcase
            end
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy); // R12
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(abort)) |-> $past(done)); // R12
    AST_ZERO_DIVISOR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dz) |-> (res_a == 32'hFFFF_FFFF && res_b == 16'hFFFF)); // R8
    AST_NORM_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_NORM && res_a != 32'h0) |-> res_a[31]); // R6
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dz && (op_q == OP_DIV32 || op_q == OP_DIV16)) |-> res_b < dv); // R2
endmodule

// File: rtl/seqmath_unit.sv
module seqmath_unit
    import seqmath_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int A_ADDR = 0,
    parameter int B_ADDR = 1,
    parameter int C_ADDR = 2,
    parameter int S_ADDR = 3,
    parameter int LAT_L  = LAT_LONG,
    parameter int LAT_S  = LAT_SHORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    logic        hit_a, hit_b, hit_c, hit_s;
    logic        wr_a, wr_b, wr_c, rd_a, rd_b, clr;
    logic [31:0] a_sh;
    logic [15:0] b_sh;
    logic [6:0]  cnt_reg;
    logic [1:0]  rp_a;
    logic        rp_b;
    logic        eng_start, eng_done, eng_busy, eng_dz, abort;
    logic [31:0] res_a;
    logic [15:0] res_b;
    op_e         op;
    seq_e        st;

    assign hit_a = bus_addr == ADDR_W'(A_ADDR);
    assign hit_b = bus_addr == ADDR_W'(B_ADDR);
    assign hit_c = bus_addr == ADDR_W'(C_ADDR);
    assign hit_s = bus_addr == ADDR_W'(S_ADDR);
    assign wr_a  = bus_wr & hit_a;
    assign wr_b  = bus_wr & hit_b;
    assign wr_c  = bus_wr & hit_c;
    assign rd_a  = bus_rd & hit_a;
    assign rd_b  = bus_rd & hit_b;
    assign clr   = bus_wr & hit_s & ~bus_wdata[2];
    assign abort = (st == ST_FAULT) | clr;

    seqmath_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
        .rd_a(rd_a), .rd_b(rd_b), .clr(clr), .done(eng_done),
        .ctl_norm(bus_wdata[CTL_NORM]), .start(eng_start), .op(op), .state(st)
    );

    seqmath_engine #(.LAT_L(LAT_L), .LAT_S(LAT_S)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .abort(abort), .op_in(op),
        .opa(a_sh), .opb({b_sh[7:0], bus_wdata}), .ctl(bus_wdata[5:0]),
        .busy(eng_busy), .done(eng_done), .dz(eng_dz), .res_a(res_a), .res_b(res_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh <= '0; b_sh <= '0; cnt_reg <= '0; rp_a <= '0; rp_b <= 1'b0;
        end else begin
            if (wr_a) a_sh <= {a_sh[23:0], bus_wdata};
            if (wr_b) b_sh <= {b_sh[7:0], bus_wdata};
            if (wr_c && eng_start) cnt_reg <= bus_wdata[6:0];
            if (eng_start || eng_done) begin
                rp_a <= '0;
                rp_b <= 1'b0;
            end else if (st == ST_IDLE) begin
                if (rd_a) rp_a <= rp_a + 1'b1;
                if (rd_b) rp_b <= ~rp_b;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (hit_a)      bus_rdata = res_a[{rp_a, 3'b000} +: 8];
            else if (hit_b) bus_rdata = res_b[{rp_b, 3'b000} +: 8];
            else if (hit_c) bus_rdata = {1'b0, cnt_reg};
            else if (hit_s) bus_rdata = {5'b0, st == ST_FAULT, eng_dz, eng_busy};
        end
    end

    AST_UNRELATED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr | bus_rd) && !(hit_a | hit_b | hit_c | hit_s) && !eng_done)
        |=> $stable(st)); // R9
    AST_FAULT_STOPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAULT) |=> !eng_busy); // R10
endmodule

// File: tb/sim_seqmath_unit.sv
module sim_seqmath_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0, rd = 1'b0, trk = 1'b0;
    logic [2:0] addr = 3'd4;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdat;
    int         n_chk = 0, n_err = 0;

    typedef struct { logic [7:0] v; int rq; } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    seqmath_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdat)
    );

    task automatic chk(input bit ok, input int rq, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d: actual %h expected %h", rq, act, expv);
        end
    endtask

    // Monitor: compare each tracked read away from the clock edge
    always @(negedge clk) begin
        item_t it;
        if (trk) begin
            if (sbq.size() == 0) chk(1'b0, 0, {24'h0, rdat}, 32'hx);
            else begin
                it = sbq.pop_front();
                chk(rdat === it.v, it.rq, {24'h0, rdat}, {24'h0, it.v});
            end
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d, input logic t);
        wr = w; rd = r; addr = a; wd = d; trk = t;
        @(posedge clk); #1;
        wr = 1'b0; rd = 1'b0; trk = 1'b0; addr = 3'd4;
    endtask

    task automatic wA(input logic [7:0] d); cyc(1'b1, 1'b0, 3'd0, d, 1'b0); endtask
    task automatic wB(input logic [7:0] d); cyc(1'b1, 1'b0, 3'd1, d, 1'b0); endtask
    task automatic wC(input logic [7:0] d); cyc(1'b1, 1'b0, 3'd2, d, 1'b0); endtask
    task automatic wS(input logic [7:0] d); cyc(1'b1, 1'b0, 3'd3, d, 1'b0); endtask
    task automatic junk(); cyc(1'b1, 1'b0, 3'd5, 8'hA5, 1'b0); cyc(1'b0, 1'b1, 3'd6, 8'h00, 1'b0); endtask

    // Driver: push expected byte, then issue the read
    task automatic rdx(input logic [2:0] a, input logic [7:0] e, input int rq);
        sbq.push_back('{v: e, rq: rq});
        cyc(1'b0, 1'b1, a, 8'h00, 1'b1);
    endtask

    task automatic rd_res(input logic [31:0] ea, input int na, input logic [15:0] eb, input int nb, input int rq);
        for (int i = 0; i < na; i++) rdx(3'd0, ea[8*i +: 8], rq);
        for (int i = 0; i < nb; i++) rdx(3'd1, eb[8*i +: 8], rq);
    endtask

    // R12: count edges from the starting write until busy drops
    task automatic wait_lat(input int lat);
        int k;
        k = 0; rd = 1'b1; addr = 3'd3; #2;
        while (rdat[0] && k < 100) begin @(posedge clk); #3; k++; end
        rd = 1'b0; addr = 3'd4;
        chk(k == lat, 12, k, lat);
        @(posedge clk); #1;
    endtask

    task automatic load_a4(input logic [31:0] a);
        for (int i = 3; i >= 0; i--) wA(a[8*i +: 8]);
    endtask

    function automatic int lz(input logic [31:0] v);
        int n;
        n = 0;
        while (n < 31 && !v[31]) begin v = v << 1; n++; end
        return n;
    endfunction

    task automatic div32(input logic [31:0] a, input logic [15:0] b, input int rq);
        load_a4(a); wB(b[15:8]); wB(b[7:0]); wait_lat(36);
        if (b == 0) rd_res(32'hFFFF_FFFF, 4, 16'hFFFF, 2, 8);
        else        rd_res(a / b, 4, 16'(a % b), 2, rq);
    endtask

    task automatic div16(input logic [15:0] a, input logic [15:0] b, input bit mix, input int rq);
        wA(a[15:8]); if (mix) junk(); wA(a[7:0]); if (mix) junk();
        wB(b[15:8]); if (mix) junk(); wB(b[7:0]); wait_lat(24);
        if (b == 0) rd_res(32'hFFFF_FFFF, 4, 16'hFFFF, 2, 8);
        else        rd_res({16'h0, a / b}, 4, a % b, 2, rq);
    endtask

    task automatic mul(input logic [15:0] a, input logic [15:0] b, input int rq);
        wB(b[15:8]); wA(a[15:8]); wA(a[7:0]); wB(b[7:0]); wait_lat(24);
        rd_res(32'(a) * 32'(b), 4, 16'h0, 0, rq);
    endtask

    task automatic shft(input logic [31:0] a, input bit right, input logic [4:0] n);
        load_a4(a); wC({1'b0, 1'b0, right, n}); wait_lat(36);
        rd_res(right ? a >> n : a << n, 4, 16'h0, 0, 5);
    endtask

    task automatic norm(input logic [31:0] a);
        int e;
        e = lz(a);
        load_a4(a); wC(8'h40); wait_lat(36);
        rd_res(a << e, 4, 16'(e), 2, 6);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        rdx(3'd3, 8'h00, 1);                           // R1 status
        rdx(3'd0, 8'h00, 1);                           // R1 result
        div32(32'h1234_5678, 16'h1234, 2);             // R2
        div32(32'hFFFF_FFFF, 16'h0003, 2);             // R2
        div16(16'hBEEF, 16'h0013, 1'b0, 3);            // R3
        div16(16'h7F31, 16'h0101, 1'b1, 9);            // R9 interleaved accesses
        mul(16'h1234, 16'hABCD, 4);                    // R4
        mul(16'hFFFF, 16'hFFFF, 4);                    // R4
        rdx(3'd0, 8'h01, 7);                           // R7 wrap to byte 0
        shft(32'h8000_0001, 1'b0, 5'd3);               // R5 left
        shft(32'h8000_0000, 1'b1, 5'd31);              // R5 right
        norm(32'h0000_1234);                           // R6
        norm(32'h0000_0000);                           // R6 zero
        norm(32'h8000_0000);                           // R6 already normal
        div16(16'h1234, 16'h0000, 1'b0, 8);            // R8
        rdx(3'd3, 8'h02, 8);                           // R8 error bit
        wS(8'h00); rdx(3'd3, 8'h00, 11);               // R11 clear error
        wA(8'h11); wB(8'h22);                          // R10 A1 then B
        rdx(3'd3, 8'h04, 10);
        load_a4(32'h0000_0001); wC(8'h01);             // R10 ignored while faulted
        rdx(3'd3, 8'h04, 10);
        wS(8'h04); rdx(3'd3, 8'h04, 11);               // R11 bit2 set: no clear
        wS(8'h00); rdx(3'd3, 8'h00, 11);               // R11
        div16(16'h0064, 16'h0007, 1'b0, 11);           // R11 works after clear
        load_a4(32'h0000_00F0); wC(8'h04);             // R10 access during run
        wA(8'h00); cyc(1'b0, 1'b0, 3'd4, 8'h00, 1'b0);
        rdx(3'd3, 8'h04, 10);
        wS(8'h00);
        wC(8'h10); rdx(3'd3, 8'h04, 10);               // R10 control write in idle
        wS(8'h00); rdx(3'd3, 8'h00, 11);
        repeat (2) @(posedge clk);
        report();
    end
endmodule